// File: doc/BRIEF.md
# Trace Trigger Delay Counter

This block holds back a trigger indication until a programmed number of trace words has been accepted after the trigger starts. The delay is the product of an 8-bit preset and a prescale factor. The prescale factor is chosen by a 5-bit select, and each select bit enables one binary prescaler stage. Together the preset and the select reach delays from one word to well over two billion words.

Software programs two values through a small write/read port: the preset (address 0) and the multiplier select (address 1). A one-cycle `trig_start` pulse arms the delay. Each cycle with `word_acc` high counts one accepted word. When the programmed count is used up, `trig_out` pulses for exactly one cycle and the block returns to idle, ready for the next start. Writes to the two registers clear the running progress in different ways, so software can retime a delay that is already in flight.

Top module: `trace_trig_delay`

## Requirements
- R1: After reset, `trig_out` is low and both readable registers (preset at address 0, select at address 1) read as zero.
- R2: Once armed, `trig_out` fires after exactly preset × 2^S accepted words, where S is the select value. Select bit 0 gives ×2, bit 1 gives ×4, bit 2 gives ×16, bit 3 gives ×256 and bit 4 gives ×65536, and the enabled factors multiply together. A select of 0 means ×1.
- R3: A preset of 0 fires on the first accepted word after the start, whatever the select is.
- R4: `trig_out` is high for exactly one cycle: the cycle that follows the clock edge that accepted the final word.
- R5: A `trig_start` pulse that arrives while a delay is running is ignored. After the indication, the counter has been reloaded and the next start begins a full delay again.
- R6: Accepted words while the block is idle have no effect and never raise `trig_out`.
- R7: Writing the preset while a delay is running restarts the word-group count from the new value, and the prescaler keeps its current phase.
- R8: Writing the select while a delay is running reloads the count from the preset and clears every prescaler stage, so the whole new delay is counted afresh.
- R9: Reads return the programmed values, not the live count. Address 0 returns the preset. Address 1 returns the select in bits 4:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_start | input | 1 | Starts a delay when the block is idle |
| word_acc | input | 1 | One trace word accepted this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 preset, 1 select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 preset, 1 select |
| rd_data | output | 8 | Read data for `rd_addr` |
| trig_out | output | 1 | One-cycle delayed trigger indication |

## Verification
A vector table sweeps preset values of 0, 1, mid-range and 255. Each is paired with single prescaler stages, combined stages and the largest single stage, so each stage's weight and the product rule are told apart from a simple sum or a wrong shift. Directed runs then start a delay and part-way through either write the preset, retrigger, or write the select. The words still needed before the indication show whether the prescaler phase was kept or cleared and whether a second start was ignored. Idle words and reads taken mid-count show that no indication appears without a start and that reads report the programmed values.

// File: rtl/trace_trig_delay.sv
module trace_trig_delay #(
  parameter int CNT_W  = 8,
  parameter int STAGES = 5,
  localparam int PRE_W = (1 << STAGES) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_start,
  input  logic             word_acc,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             trig_out
);

  logic [CNT_W-1:0]  preset_q, cnt_q;
  logic [STAGES-1:0] sel_q;
  logic [PRE_W-1:0]  pre_q, pre_mask;
  logic              armed_q;

  // stage i contributes factor 2^(2^i): total prescale is 2^sel
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign pre_mask[i] = (sel_q > STAGES'(i));
  end

  wire pre_tc     = (pre_q == pre_mask);
  wire wr_preset  = wr_en & ~wr_addr;
  wire wr_sel     = wr_en &  wr_addr;
  wire step       = armed_q & word_acc;
  wire fire       = step & ((cnt_q == '0) | (pre_tc & (cnt_q == CNT_W'(1))));

  assign rd_data = rd_addr ? CNT_W'(sel_q) : preset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      sel_q    <= '0;
      cnt_q    <= '0;
      pre_q    <= '0;
      armed_q  <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= fire;
      if (wr_preset) preset_q <= wr_data;
      if (wr_sel)    sel_q    <= wr_data[STAGES-1:0];

      if (fire)            armed_q <= 1'b0;
      else if (trig_start) armed_q <= 1'b1;

      if (trig_start && !armed_q) begin
        cnt_q <= preset_q;
        pre_q <= '0;
      end else if (step) begin
        if (fire)        cnt_q <= preset_q;
        else if (pre_tc) cnt_q <= cnt_q - CNT_W'(1);
        pre_q <= pre_tc ? '0 : pre_q + PRE_W'(1);
      end

      if (wr_sel) begin
        cnt_q <= preset_q;
        pre_q <= '0;
      end else if (wr_preset) begin
        cnt_q <= wr_data;
      end
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q) |=> !trig_out);

  // R7
  preset_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_preset |=> (cnt_q == $past(wr_data)) && (preset_q == $past(wr_data)));

  // R8
  sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (pre_q == '0) && (cnt_q == $past(preset_q)));

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_mask);

endmodule

// File: tb/trace_trig_delay_test.sv
module trace_trig_delay_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_start = 0, word_acc = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic trig_out;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  trace_trig_delay uut (.clk, .rst_n, .trig_start, .word_acc, .wr_en, .wr_addr,
    .wr_data, .rd_addr, .rd_data, .trig_out);

  localparam int NV = 11;
  localparam int VP [NV] = '{0, 1, 5, 3, 2, 1, 3, 255, 4, 1, 1};
  localparam int VS [NV] = '{7, 0, 0, 1, 2, 3, 4, 0, 5, 8, 16};
  localparam int VN [NV] = '{1, 1, 5, 6, 8, 8, 48, 255, 128, 256, 65536};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic start();
    trig_start = 1;
    @(negedge clk);
    trig_start = 0;
  endtask

  task automatic run(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      word_acc = 1;
      @(negedge clk);
      word_acc = 0;
      if (trig_out) begin n = i; break; end
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(trig_out == 0, "R1", trig_out, 0);
    rd_addr = 0; #0 chk(rd_data == 0, "R1", rd_data, 0);
    rd_addr = 1; #0 chk(rd_data == 0, "R1", rd_data, 0);

    // R2 R3 R4 vector sweep
    for (int v = 0; v < NV; v++) begin
      wr(0, 8'(VP[v]));
      wr(1, 8'(VS[v]));
      start();
      run(VN[v] + 2, n);
      chk(n == VN[v], (VP[v] == 0) ? "R3" : "R2", n, VN[v]);
      @(negedge clk);
      chk(trig_out == 0, "R4", trig_out, 0);
    end

    // R6
    run(20, n);
    chk(n == 0, "R6", n, 0);

    // R5 and R9
    wr(0, 3); wr(1, 0);
    start();
    run(2, n);
    chk(n == 0, "R5", n, 0);
    rd_addr = 0; #0 chk(rd_data == 3, "R9", rd_data, 3);
    start();
    run(10, n);
    chk(n == 1, "R5", n, 1);
    start();
    run(10, n);
    chk(n == 3, "R5", n, 3);
    wr(1, 8'h15);
    rd_addr = 1; #0 chk(rd_data == 8'h15, "R9", rd_data, 8'h15);

    // R7: prescaler phase kept across preset write
    wr(0, 2); wr(1, 1);
    start();
    run(1, n);
    wr(0, 1);
    run(5, n);
    chk(n == 1, "R7", n, 1);

    // R8: select write clears progress
    wr(0, 2); wr(1, 1);
    start();
    run(3, n);
    chk(n == 0, "R8", n, 0);
    wr(1, 1);
    run(8, n);
    chk(n == 4, "R8", n, 4);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule